// File: doc/BRIEF.md
# Single-Cell Pack Guard Controller

This block is the digital decision core of a one-cell battery pack protector. It receives comparator results that are already digital: the cell above the overvoltage trip, the cell below the overvoltage release, the cell below the undervoltage trip, the cell above the undervoltage release, a discharge overcurrent, a charger present, the pack-minus terminal near battery-minus, and an overtemperature flag. From these it chooses the mode of the pack pass switch and drives it as a 3-bit code. The analog front end, the gate drive loop and the switch itself sit outside the block.

The controller runs from a slow system clock. It divides that clock down to a periodic voltage sample strobe, and it times fault persistence in clock ticks. Each fault has its own qualification rule and its own way out. An overvoltage must persist and clears on a voltage level. An undervoltage needs repeated samples and clears only after a charger appears. An overcurrent is timed every cycle and clears only when the load is removed. Overtemperature overrides everything while it is asserted.

Top module: `cell_guard_ctrl`

## Requirements
- R1: A synchronous active-high `rst` puts the block in its normal state, with `sw_mode` = 3'b000 (switch fully on) and `sample_stb` = 0.
- R2: `sample_stb` is a one-cycle pulse that repeats every SAMPLE_TICKS cycles. The first pulse comes SAMPLE_TICKS cycles after reset is released. Voltage flags act only in cycles where the strobe is high.
- R3: The normal state moves to overvoltage only in a strobe cycle in which `cell_over_trip` is high and has already been high for at least OV_HOLD_TICKS consecutive earlier cycles.
- R4: In overvoltage, `sw_mode` = 3'b001 (charge blocked, discharge through the linear loop). Only a strobe cycle with `cell_under_ovrel` high returns the block to normal. The trip flag falling while the cell is still inside the hysteresis band changes nothing.
- R5: The normal state moves to undervoltage only after UV_SAMPLES (default 2) consecutive strobes with `cell_under_uvtrip` high. A single low sample does not trip.
- R6: In undervoltage sleep, `sw_mode` = 3'b100. The block stays there, whatever the voltage flags do, until `charger_seen` goes high.
- R7: A charger seen during sleep gives `sw_mode` = 3'b010 (charge only, linear loop). From there, a strobe with `cell_over_uvrel` high returns to normal, and losing the charger returns to sleep.
- R8: In the normal and overvoltage states, `dsg_overcur` trips a fault only if it stays high for more than OC_HOLD_TICKS consecutive cycles. A burst of OC_HOLD_TICKS cycles or fewer is ignored. In the normal state, an overcurrent takes priority over undervoltage, and undervoltage takes priority over overvoltage.
- R9: After an overcurrent trip, `sw_mode` = 3'b011 (off). It stays off until `packneg_near` goes high, and the block then returns to normal.
- R10: While `over_temp` is high, `sw_mode` is 3'b011 from the next cycle on, and the protection state is frozen. When `over_temp` falls, the mode of the frozen state comes back.
- R11: The overvoltage and overcurrent persistence timers restart from zero whenever their flag drops, even for a single cycle.
- R12: `sw_mode` only ever takes the codes 3'b000 to 3'b100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow system clock |
| rst | input | 1 | Synchronous active-high reset |
| cell_over_trip | input | 1 | Cell above the overvoltage trip level |
| cell_under_ovrel | input | 1 | Cell below the overvoltage release level |
| cell_under_uvtrip | input | 1 | Cell below the undervoltage trip level |
| cell_over_uvrel | input | 1 | Cell above the undervoltage release level |
| dsg_overcur | input | 1 | Discharge current above the limit |
| charger_seen | input | 1 | Charger detected on the pack terminals |
| packneg_near | input | 1 | Pack-minus pulled to within 50 mV of battery-minus |
| over_temp | input | 1 | Die overtemperature |
| sw_mode | output | 3 | Pass switch mode code |
| sample_stb | output | 1 | Voltage sample strobe |

## Verification
The in-RTL assertions check, on every cycle, several properties of the fault logic. The strobe is a single-cycle pulse, and the timers drop whenever their flag drops. Every entry into overvoltage, undervoltage or the overcurrent trip is backed by a strobe or an expired timer. The overcurrent trip and the sleep state hold until their release event. Overtemperature forces the switch off and freezes the state, and the mode code stays legal.

Only the bench scenarios can show the exact cycle counts. These include a flag that drops just before its timer expires, a lone low sample, a dwell inside the hysteresis band, the charger coming and going, and the return to the frozen mode after an overtemperature episode. The bench shows these by comparing the outputs with a behavioural model on every clock.

// File: rtl/cgp_pkg.sv
package cgp_pkg;

  // Pass switch mode codes seen at the top-level port
  typedef enum logic [2:0] {
    SW_FULL      = 3'd0,  // fully on
    SW_CHG_BLOCK = 3'd1,  // discharge only, linear loop
    SW_DSG_BLOCK = 3'd2,  // charge only, linear loop
    SW_OFF       = 3'd3,  // switch open
    SW_SLEEP     = 3'd4   // open, low-power sleep
  } sw_mode_e;

  // Protection states
  typedef enum logic [2:0] {
    ST_RUN     = 3'd0,
    ST_HIGHV   = 3'd1,
    ST_TRIP    = 3'd2,
    ST_DORMANT = 3'd3,
    ST_RECOVER = 3'd4
  } guard_st_e;

  function automatic sw_mode_e mode_of(guard_st_e s);
    case (s)
      ST_RUN:     return SW_FULL;
      ST_HIGHV:   return SW_CHG_BLOCK;
      ST_TRIP:    return SW_OFF;
      ST_DORMANT: return SW_SLEEP;
      ST_RECOVER: return SW_DSG_BLOCK;
      default:    return SW_OFF;
    endcase
  endfunction

endpackage

// File: rtl/cgp_tick_gen.sv
module cgp_tick_gen #(
  parameter int unsigned PERIOD = 262
) (
  input  logic clk,
  input  logic rst,
  output logic stb_o
);
  localparam int unsigned CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  generate
    if (PERIOD > 1) begin : g_div
      logic [CW-1:0] cnt_q;
      logic          wrap;
      assign wrap = (cnt_q == CW'(PERIOD - 1));

      always_ff @(posedge clk) begin
        if (rst) begin
          cnt_q <= '0;
          stb_o <= 1'b0;
        end else begin
          stb_o <= wrap;
          cnt_q <= wrap ? '0 : cnt_q + 1'b1;
        end
      end

      // R2: strobe is a single-cycle pulse
      p_stb_single_r2: assert property (@(posedge clk) disable iff (rst)
        stb_o |=> !stb_o);
    end else begin : g_every
      always_ff @(posedge clk) begin
        if (rst) stb_o <= 1'b0;
        else     stb_o <= 1'b1;
      end
    end
  endgenerate

endmodule

// File: rtl/cgp_hold_timer.sv
module cgp_hold_timer #(
  parameter int unsigned LIMIT = 33
) (
  input  logic clk,
  input  logic rst,
  input  logic cond_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !cond_i)               cnt_q <= '0;
    else if (cnt_q != CW'(LIMIT))     cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == CW'(LIMIT));

  // R11: a dropped flag leaves no accumulated time
  p_restart_r11: assert property (@(posedge clk) disable iff (rst)
    !cond_i |=> !done_o);

  // R11: expiry needs the flag high on the preceding cycle
  p_done_needs_cond_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> $past(cond_i));

endmodule

// File: rtl/cgp_guard_fsm.sv
module cgp_guard_fsm
  import cgp_pkg::*;
#(
  parameter int unsigned UV_HITS = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     stb_i,
  input  logic     ov_hold_i,
  input  logic     oc_hold_i,
  input  logic     ov_trip_i,
  input  logic     ov_clear_i,
  input  logic     uv_trip_i,
  input  logic     uv_clear_i,
  input  logic     oc_i,
  input  logic     chg_i,
  input  logic     near_i,
  input  logic     ot_i,
  output sw_mode_e mode_o
);
  localparam int unsigned UW = $clog2(UV_HITS + 1);

  guard_st_e     st_q, st_d;
  logic [UW-1:0] uv_q, uv_d;
  logic          oc_fire;

  assign oc_fire = oc_hold_i && oc_i;

  always_comb begin
    st_d = st_q;
    uv_d = uv_q;
    if (!ot_i) begin
      case (st_q)
        ST_RUN: begin
          if (oc_fire) begin
            st_d = ST_TRIP;
            uv_d = '0;
          end else if (stb_i) begin
            if (uv_trip_i) begin
              if (uv_q >= UW'(UV_HITS - 1)) begin
                st_d = ST_DORMANT;
                uv_d = '0;
              end else begin
                uv_d = uv_q + 1'b1;
              end
            end else begin
              uv_d = '0;
              if (ov_trip_i && ov_hold_i) st_d = ST_HIGHV;
            end
          end
        end
        ST_HIGHV: begin
          if (oc_fire)                  st_d = ST_TRIP;
          else if (stb_i && ov_clear_i) st_d = ST_RUN;
        end
        ST_TRIP: begin
          if (near_i) st_d = ST_RUN;
        end
        ST_DORMANT: begin
          if (chg_i) st_d = ST_RECOVER;
        end
        ST_RECOVER: begin
          if (!chg_i)                   st_d = ST_DORMANT;
          else if (stb_i && uv_clear_i) st_d = ST_RUN;
        end
        default: st_d = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_RUN;
      uv_q   <= '0;
      mode_o <= SW_FULL;
    end else begin
      st_q   <= st_d;
      uv_q   <= uv_d;
      mode_o <= ot_i ? SW_OFF : mode_of(st_d);
    end
  end

  // R3: overvoltage entry only at a strobe with an expired hold timer
  p_ov_entry_r3: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_HIGHV && $past(st_q) == ST_RUN) |-> ($past(stb_i) && $past(ov_hold_i)));

  // R5: undervoltage entry only at a strobe with the trip flag high
  p_uv_entry_r5: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_DORMANT && $past(st_q) == ST_RUN) |-> ($past(stb_i) && $past(uv_trip_i)));

  // R8: overcurrent trip only after the timer expired
  p_oc_entry_r8: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_TRIP && $past(st_q) != ST_TRIP) |-> $past(oc_hold_i));

  // R9: trip latched until the pack terminal is pulled down
  p_oc_latch_r9: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_TRIP && !near_i) |=> st_q == ST_TRIP);

  // R6: sleep holds until a charger appears
  p_sleep_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_DORMANT && !chg_i) |=> st_q == ST_DORMANT);

  // R10: overtemperature opens the switch and freezes the state
  p_ot_freeze_r10: assert property (@(posedge clk) disable iff (rst)
    ot_i |=> (mode_o == SW_OFF && st_q == $past(st_q)));

endmodule

// File: rtl/cell_guard_ctrl.sv
module cell_guard_ctrl
  import cgp_pkg::*;
#(
  parameter int unsigned SAMPLE_TICKS  = 262,
  parameter int unsigned OV_HOLD_TICKS = 32768,
  parameter int unsigned OC_HOLD_TICKS = 33,
  parameter int unsigned UV_SAMPLES    = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cell_over_trip,
  input  logic       cell_under_ovrel,
  input  logic       cell_under_uvtrip,
  input  logic       cell_over_uvrel,
  input  logic       dsg_overcur,
  input  logic       charger_seen,
  input  logic       packneg_near,
  input  logic       over_temp,
  output logic [2:0] sw_mode,
  output logic       sample_stb
);
  logic     ov_hold, oc_hold;
  sw_mode_e mode_q;

  cgp_tick_gen #(.PERIOD(SAMPLE_TICKS)) u_tick (
    .clk   (clk),
    .rst   (rst),
    .stb_o (sample_stb)
  );

  cgp_hold_timer #(.LIMIT(OV_HOLD_TICKS)) u_ov_timer (
    .clk    (clk),
    .rst    (rst),
    .cond_i (cell_over_trip),
    .done_o (ov_hold)
  );

  cgp_hold_timer #(.LIMIT(OC_HOLD_TICKS)) u_oc_timer (
    .clk    (clk),
    .rst    (rst),
    .cond_i (dsg_overcur),
    .done_o (oc_hold)
  );

  cgp_guard_fsm #(.UV_HITS(UV_SAMPLES)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .stb_i      (sample_stb),
    .ov_hold_i  (ov_hold),
    .oc_hold_i  (oc_hold),
    .ov_trip_i  (cell_over_trip),
    .ov_clear_i (cell_under_ovrel),
    .uv_trip_i  (cell_under_uvtrip),
    .uv_clear_i (cell_over_uvrel),
    .oc_i       (dsg_overcur),
    .chg_i      (charger_seen),
    .near_i     (packneg_near),
    .ot_i       (over_temp),
    .mode_o     (mode_q)
  );

  assign sw_mode = mode_q;

  // R12: only the five defined codes appear
  p_mode_legal_r12: assert property (@(posedge clk) disable iff (rst)
    sw_mode <= 3'd4);

endmodule

// File: tb/sim_cell_guard_ctrl.sv
`timescale 1ns/1ps
module sim_cell_guard_ctrl;
  localparam int SMP = 4;
  localparam int OVT = 20;
  localparam int OCT = 5;
  localparam int UVN = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ovt = 0, ovr = 1, uvt = 0, uvr = 1, oc = 0, chg = 0, near = 0, ot = 0;
  logic [2:0] sw_mode;
  logic       sample_stb;

  always #2 clk = ~clk;

  cell_guard_ctrl #(
    .SAMPLE_TICKS(SMP), .OV_HOLD_TICKS(OVT), .OC_HOLD_TICKS(OCT), .UV_SAMPLES(UVN)
  ) u0 (
    .clk(clk), .rst(rst), .cell_over_trip(ovt), .cell_under_ovrel(ovr),
    .cell_under_uvtrip(uvt), .cell_over_uvrel(uvr), .dsg_overcur(oc),
    .charger_seen(chg), .packneg_near(near), .over_temp(ot),
    .sw_mode(sw_mode), .sample_stb(sample_stb)
  );

  int n_chk = 0, n_bad = 0;
  string cur_req = "R1";
  bit done = 0;

  // Behavioural reference: states 0 normal, 1 overvoltage, 2 trip, 3 sleep, 4 charge-only
  int m_cnt, m_ovc, m_occ, m_uvn, m_st, m_mode, t_ns;
  bit m_stb, t_stb, t_ovq, t_ocq;

  function automatic int code_of(int s);
    case (s)
      0: return 0;
      1: return 1;
      2: return 3;
      3: return 4;
      default: return 2;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_stb = 0; m_ovc = 0; m_occ = 0; m_uvn = 0; m_st = 0; m_mode = 0;
    end else begin
      t_stb = m_stb; t_ovq = (m_ovc == OVT); t_ocq = (m_occ == OCT); t_ns = m_st;
      if (!ot) begin
        if (m_st == 0) begin
          if (t_ocq && oc) begin t_ns = 2; m_uvn = 0; end
          else if (t_stb) begin
            if (uvt) begin
              m_uvn++;
              if (m_uvn >= UVN) begin t_ns = 3; m_uvn = 0; end
            end else begin
              m_uvn = 0;
              if (ovt && t_ovq) t_ns = 1;
            end
          end
        end else if (m_st == 1) begin
          if (t_ocq && oc) t_ns = 2;
          else if (t_stb && ovr) t_ns = 0;
        end else if (m_st == 2) begin
          if (near) t_ns = 0;
        end else if (m_st == 3) begin
          if (chg) t_ns = 4;
        end else begin
          if (!chg) t_ns = 3;
          else if (t_stb && uvr) t_ns = 0;
        end
      end
      m_st = t_ns;
      m_mode = ot ? 3 : code_of(t_ns);
      m_stb = (m_cnt == SMP - 1);
      m_cnt = (m_cnt == SMP - 1) ? 0 : m_cnt + 1;
      m_ovc = ovt ? ((m_ovc < OVT) ? m_ovc + 1 : OVT) : 0;
      m_occ = oc ? ((m_occ < OCT) ? m_occ + 1 : OCT) : 0;
    end
  end

  task automatic chk(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, got, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk({cur_req, " mode"}, sw_mode, m_mode);
      chk({cur_req, " strobe"}, sample_stb, m_stb);
      chk("R12 legal code", (sw_mode <= 3'd4), 1);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=complete");
    finish_run();
  end

  initial begin
    int stb_seen;
    cyc(3);
    rst = 0;
    chk("R1 reset mode", sw_mode, 0);
    chk("R1 reset strobe", sample_stb, 0);

    // R2: ten strobes in forty cycles
    cur_req = "R2";
    stb_seen = 0;
    for (int i = 0; i < 40; i++) begin
      cyc(1);
      if (sample_stb) stb_seen++;
    end
    chk("R2 strobe count", stb_seen, 10);

    // R11/R3: interrupted overvoltage does not accumulate
    cur_req = "R11";
    ovr = 0; ovt = 1; cyc(10);
    ovt = 0; cyc(1);
    ovt = 1; cyc(15);
    chk("R11 ov timer restarted", sw_mode, 0);
    cur_req = "R3";
    cyc(30);
    chk("R3 ov entered", sw_mode, 1);
    cur_req = "R4";
    ovt = 0; cyc(20);
    chk("R4 hysteresis band holds", sw_mode, 1);
    ovr = 1; cyc(8);
    chk("R4 released", sw_mode, 0);

    // R1: reset mid-fault
    cur_req = "R1";
    ovr = 0; ovt = 1; cyc(30);
    rst = 1; cyc(2); rst = 0;
    chk("R1 reset from ov mode", sw_mode, 0);
    chk("R1 reset from ov strobe", sample_stb, 0);
    ovt = 0; ovr = 1; cyc(8);

    // R8/R11: short bursts ignored
    cur_req = "R8";
    oc = 1; cyc(OCT); oc = 0; cyc(4);
    chk("R8 burst of limit ignored", sw_mode, 0);
    cur_req = "R11";
    oc = 1; cyc(4); oc = 0; cyc(1); oc = 1; cyc(4); oc = 0; cyc(4);
    chk("R11 oc timer restarted", sw_mode, 0);
    cur_req = "R9";
    oc = 1; cyc(10); oc = 0;
    chk("R9 oc trip", sw_mode, 3);
    cyc(20);
    chk("R9 trip latched", sw_mode, 3);
    near = 1; cyc(1); near = 0; cyc(3);
    chk("R9 cleared by pulldown", sw_mode, 0);

    // R5: one low sample does not trip
    cur_req = "R5";
    uvt = 1; cyc(3); uvt = 0; cyc(8);
    chk("R5 single sample ignored", sw_mode, 0);
    uvt = 1; uvr = 0; cyc(12);
    chk("R5 uv entered", sw_mode, 4);
    cur_req = "R6";
    uvt = 0; cyc(20);
    chk("R6 sleep held", sw_mode, 4);
    cur_req = "R7";
    chg = 1; cyc(3);
    chk("R7 charge only", sw_mode, 2);
    chg = 0; cyc(3);
    chk("R7 charger lost", sw_mode, 4);
    chg = 1; cyc(3);
    uvr = 1; cyc(8);
    chk("R7 normal resumed", sw_mode, 0);
    chg = 0; cyc(2);

    // R10: overtemperature override and resume
    cur_req = "R10";
    ot = 1; cyc(2);
    chk("R10 forced off", sw_mode, 3);
    ot = 0; cyc(2);
    chk("R10 released normal", sw_mode, 0);
    ovr = 0; ovt = 1; cyc(30);
    chk("R10 ov before override", sw_mode, 1);
    ot = 1; ovt = 0; cyc(10);
    chk("R10 off in ov", sw_mode, 3);
    ot = 0; cyc(2);
    chk("R10 frozen ov restored", sw_mode, 1);
    ovr = 1; cyc(8);
    chk("R10 evaluation resumed", sw_mode, 0);

    finish_run();
  end
endmodule